// File: doc/BRIEF.md
# Metaframe Scrambler with Self-Synchronous Mode

This block scrambles a 64-bit word stream, one word per clock. It has two modes, chosen by a mode pin. In frame-synchronous mode, a word counter splits the stream into metaframes. The block replaces the first slot of each metaframe with a fixed synchronization word. It replaces the second slot with a clear-text copy of its live 58-bit LFSR state, so a receiver can reseed from that word. Every other word is XORed with an additive keystream from the polynomial x^58 + x^39 + 1.

In self-synchronous mode, every valid word is scrambled multiplicatively with the same polynomial. Each scrambled bit is fed back into the state. Once seeded, the scrambler runs without any periodic resynchronization. In both modes, a 2-bit sync header travels beside the word and is never scrambled.

Upstream logic supplies placeholder words for the two header slots of each metaframe; the block discards their contents. A seed-load strobe writes the LFSR state from the low bits of the data input.

Top module: `metaframe_scrambler`

## Requirements
- R1: After reset, out_valid and out_data are 0, out_hdr is 2'b00, the metaframe counter is at slot 0, and the LFSR state equals the SEED_INIT parameter.
- R2: Each accepted word (in_valid high, seed_load low) produces out_valid high with its result one clock later. When in_valid is low, out_valid is low one clock later.
- R3: In frame-synchronous mode (mode = 0), the result for metaframe slot 0 is the SYNC_WORD parameter. The input data of that slot is ignored.
- R4: In frame-synchronous mode, the result for slot 1 is {6'b0, state[57:0]}, taken before any advance. The input data is ignored, and the state does not advance in slots 0 and 1.
- R5: In frame-synchronous mode, a word in slot 2 or later is output as in_data XOR keystream. Keystream bit i (i = 0 first) is f = s[57] ^ s[38], after which s becomes {s[56:0], f}. So 64 steps are taken per payload word.
- R6: The slot counter wraps from MF_LEN-1 to 0, so the next word is again the sync word. The LFSR state carries across metaframe boundaries without reset.
- R7: In self-synchronous mode (mode = 1), output bit i is o = d[i] ^ s[57] ^ s[38], after which s becomes {s[56:0], o}, for i = 0 to 63. Every accepted word is scrambled.
- R8: out_hdr equals the in_hdr of the accepted word in both modes, unchanged.
- R9: When seed_load is high, the state takes in_data[57:0] and the slot counter returns to 0. No output is produced (out_valid is low one clock later), even if in_valid is also high.
- R10: Cycles with in_valid low leave the LFSR state and the slot counter unchanged. A stream with idle gaps therefore gives the same results as one without gaps.
- R11: While mode is 1, the slot counter is held at 0. The first frame-synchronous word after a return to mode 0 is the sync word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 64 | Input word; low 58 bits also carry the seed |
| in_hdr | input | 2 | Sync header passed beside the word |
| mode | input | 1 | 0 = frame-synchronous, 1 = self-synchronous |
| seed_load | input | 1 | Load the LFSR state from in_data[57:0] |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 64 | Scrambled, sync or state word |
| out_hdr | output | 2 | Sync header of the output word |

## Verification
Every accepted word has its result, valid strobe and header registered on the next rising edge. A seed-load cycle has no result; the clock after it shows out_valid low. The driver applies inputs on falling edges and pushes the expected word into a queue at that moment. The monitor pops and compares on each later falling edge where out_valid is high, which is exactly one clock after the word was applied. Idle gaps and seed cycles must therefore leave no extra items in the queue, and each popped item is compared against a bit-serial reference model of both polynomials.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    MODE_FRAME = 1'b0,
    MODE_SELF  = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/mf_word_ctr.sv
module mf_word_ctr #(
  parameter int MF_LEN = 2048,
  localparam int CNT_W = (MF_LEN > 2) ? $clog2(MF_LEN) : 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             at_slot0,
  output logic             at_slot1
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);
  logic [CNT_W-1:0] cnt_inc;

  generate
    if ((MF_LEN & (MF_LEN - 1)) == 0 && MF_LEN > 2) begin : g_pow2
      // counter width matches the length exactly: natural wrap
      assign cnt_inc = cnt + CNT_W'(1);
    end else begin : g_mod
      assign cnt_inc = (cnt == LAST) ? '0 : cnt + CNT_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt_inc;
  end

  assign at_slot0 = (cnt == '0);
  assign at_slot1 = (cnt == CNT_W'(1));

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_cnt_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && cnt == LAST) |=> cnt == '0);
  assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/add_keystream.sv
module add_keystream #(
  parameter int DATA_W = 64,
  parameter int LFSR_W = 58,
  parameter int TAP    = 39
) (
  input  logic [LFSR_W-1:0] state_in,
  output logic [DATA_W-1:0] key,
  output logic [LFSR_W-1:0] state_out
);
  logic [LFSR_W-1:0] s;
  logic              fb;

  // additive generator: keystream independent of the data
  always_comb begin
    s   = state_in;
    key = '0;
    fb  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      fb     = s[LFSR_W-1] ^ s[TAP-1];
      key[i] = fb;
      s      = {s[LFSR_W-2:0], fb};
    end
    state_out = s;
  end
endmodule

// File: rtl/mul_scramble.sv
module mul_scramble #(
  parameter int DATA_W = 64,
  parameter int LFSR_W = 58,
  parameter int TAP    = 39
) (
  input  logic [LFSR_W-1:0] state_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LFSR_W-1:0] state_out
);
  logic [LFSR_W-1:0] s;
  logic              ob;

  // multiplicative scrambler: each output bit re-enters the state
  always_comb begin
    s    = state_in;
    dout = '0;
    ob   = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      ob      = din[i] ^ s[LFSR_W-1] ^ s[TAP-1];
      dout[i] = ob;
      s       = {s[LFSR_W-2:0], ob};
    end
    state_out = s;
  end
endmodule

// File: rtl/metaframe_scrambler.sv
module metaframe_scrambler
  import scr_pkg::*;
#(
  parameter int              DATA_W    = 64,
  parameter int              LFSR_W    = 58,
  parameter int              TAP       = 39,
  parameter int              HDR_W     = 2,
  parameter int              MF_LEN    = 2048,
  parameter logic [63:0]     SYNC_WORD = 64'h78F6_78F6_78F6_78F6,
  parameter logic [57:0]     SEED_INIT = 58'h123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       in_data,
  input  logic [1:0]        in_hdr,
  input  logic              mode,
  input  logic              seed_load,
  output logic              out_valid,
  output logic [63:0]       out_data,
  output logic [1:0]        out_hdr
);
  localparam int PAD_W = DATA_W - LFSR_W;
  localparam int CNT_W = (MF_LEN > 2) ? $clog2(MF_LEN) : 2;

  logic [LFSR_W-1:0] state, next_state;
  logic [DATA_W-1:0] key, mul_out, state_word, nxt_data;
  logic [LFSR_W-1:0] add_st, mul_st;
  logic [CNT_W-1:0]  cnt;
  logic              at_slot0, at_slot1;
  logic              accept, self_m, ctr_clr, ctr_adv;

  assign self_m  = (mode == MODE_SELF);
  assign accept  = in_valid && !seed_load;
  assign ctr_clr = seed_load || self_m;
  assign ctr_adv = accept && !self_m;

  mf_word_ctr #(.MF_LEN(MF_LEN)) u_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .adv(ctr_adv),
    .cnt(cnt), .at_slot0(at_slot0), .at_slot1(at_slot1)
  );

  add_keystream #(.DATA_W(DATA_W), .LFSR_W(LFSR_W), .TAP(TAP)) u_add (
    .state_in(state), .key(key), .state_out(add_st)
  );

  mul_scramble #(.DATA_W(DATA_W), .LFSR_W(LFSR_W), .TAP(TAP)) u_mul (
    .state_in(state), .din(in_data), .dout(mul_out), .state_out(mul_st)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign state_word = {{PAD_W{1'b0}}, state};
    end else begin : g_nopad
      assign state_word = state[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    next_state = state;
    nxt_data   = in_data ^ key;
    if (seed_load) begin
      next_state = in_data[LFSR_W-1:0];
    end else if (in_valid) begin
      if (self_m) begin
        nxt_data   = mul_out;
        next_state = mul_st;
      end else if (at_slot0) begin
        nxt_data = SYNC_WORD;
      end else if (at_slot1) begin
        nxt_data = state_word;
      end else begin
        next_state = add_st;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEED_INIT;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_hdr   <= '0;
    end else begin
      state     <= next_state;
      out_valid <= accept;
      if (accept) begin
        out_data <= nxt_data;
        out_hdr  <= in_hdr;
      end
    end
  end

  assert_valid_src_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && !seed_load));
  assert_sync_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !self_m && cnt == '0) |=> out_data == SYNC_WORD);
  assert_state_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !self_m && cnt == CNT_W'(1)) |=> (out_data[LFSR_W-1:0] == state && $stable(state)));
  assert_hdr_pass_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_hdr == $past(in_hdr));
  assert_seed_R9: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (state == $past(in_data[LFSR_W-1:0]) && !out_valid));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !seed_load) |=> ($stable(state) && !out_valid));
  assert_self_ctr_R11: assert property (@(posedge clk) disable iff (rst)
    self_m |=> cnt == '0);
endmodule

// File: tb/tb_metaframe_scrambler.sv
`timescale 1ns/1ps
module tb_metaframe_scrambler;
  localparam int          LW   = 58;
  localparam int          TP   = 39;
  localparam int          MFL  = 5;
  localparam logic [63:0] SYNC = 64'h78F6_78F6_78F6_78F6;
  localparam logic [57:0] SD0  = 58'h123_4567_89AB_CDEF;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, mode = 1'b0, seed_load = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0]  in_hdr = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [1:0]  out_hdr;

  always #4 clk = ~clk;

  metaframe_scrambler #(.MF_LEN(MFL), .SYNC_WORD(SYNC), .SEED_INIT(SD0)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_hdr(in_hdr),
    .mode(mode), .seed_load(seed_load), .out_valid(out_valid),
    .out_data(out_data), .out_hdr(out_hdr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [63:0] q_data[$];
  logic [1:0]  q_hdr[$];
  string       q_tag[$];
  logic [LW-1:0] m_st = SD0;
  int            m_cnt = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model, one LFSR step at a time
  task automatic put(input logic [63:0] d, input logic [1:0] h, input bit self_m, input string tag);
    logic [63:0] e;
    logic b;
    e = '0;
    if (self_m) begin
      for (int i = 0; i < 64; i++) begin
        b = d[i] ^ m_st[LW-1] ^ m_st[TP-1];
        e[i] = b;
        m_st = {m_st[LW-2:0], b};
      end
      m_cnt = 0;
    end else begin
      if (m_cnt == 0) e = SYNC;
      else if (m_cnt == 1) e = {6'b0, m_st};
      else begin
        for (int i = 0; i < 64; i++) begin
          b = m_st[LW-1] ^ m_st[TP-1];
          e[i] = d[i] ^ b;
          m_st = {m_st[LW-2:0], b};
        end
      end
      m_cnt = (m_cnt + 1) % MFL;
    end
    @(negedge clk);
    in_valid = 1'b1; seed_load = 1'b0; mode = self_m; in_data = d; in_hdr = h;
    q_data.push_back(e); q_hdr.push_back(h); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; seed_load = 1'b0; in_data = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  task automatic seed(input logic [LW-1:0] s);
    @(negedge clk);
    in_valid = 1'b1; seed_load = 1'b1; in_data = {6'h3F, s}; in_hdr = 2'b11;
    m_st = s; m_cnt = 0;
    @(negedge clk);
    in_valid = 1'b0; seed_load = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 no output for seed cycle", {63'b0, out_valid}, 64'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R2 unexpected output", out_data, 64'd0);
      end else begin
        logic [63:0] ed;
        logic [1:0]  eh;
        string       t;
        ed = q_data.pop_front(); eh = q_hdr.pop_front(); t = q_tag.pop_front();
        check(out_data === ed, t, out_data, ed);
        check(out_hdr === eh, "R8 header passthrough", {62'b0, out_hdr}, {62'b0, eh});
      end
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0 && out_hdr == '0, "R1 reset outputs",
          {out_data[62:0], out_valid}, 64'd0);
    // metaframe 1: sync, state (= SEED_INIT), payloads
    put(64'h1111_2222_3333_4444, 2'b01, 1'b0, "R3 sync word");
    put(64'h5555_6666_7777_8888, 2'b10, 1'b0, "R1 initial state word");
    put(64'h0, 2'b01, 1'b0, "R5 payload zero");
    put('1, 2'b01, 1'b0, "R5 payload ones");
    put(64'h0123_4567_89AB_CDEF, 2'b10, 1'b0, "R5 payload pattern");
    // metaframe 2 with idle gaps
    put(64'hAAAA_AAAA_AAAA_AAAA, 2'b01, 1'b0, "R6 wrap to sync");
    idle(2);
    put(64'h0, 2'b10, 1'b0, "R4 state word carries on");
    idle(3);
    put(64'hFEDC_BA98_7654_3210, 2'b01, 1'b0, "R10 payload after gap");
    idle(1);
    put(64'h5A5A_5A5A_A5A5_A5A5, 2'b10, 1'b0, "R10 payload after gap");
    put(64'h1, 2'b01, 1'b0, "R5 last payload");
    // reseed mid-stream
    seed(58'h2AA_5555_AAAA_5555);
    put(64'h9, 2'b10, 1'b0, "R9 sync after seed");
    put(64'h9, 2'b01, 1'b0, "R9 state word equals seed");
    put(64'h8000_0000_0000_0001, 2'b10, 1'b0, "R5 payload after seed");
    // self-synchronous mode mid-metaframe
    put(64'h0, 2'b10, 1'b1, "R7 self-sync zero");
    put('1, 2'b01, 1'b1, "R7 self-sync ones");
    idle(2);
    put(64'hC3C3_3C3C_0F0F_F0F0, 2'b10, 1'b1, "R7 self-sync after gap");
    seed(58'h3FF_FFFF_FFFF_FFFF);
    put(64'h1234_5678_9ABC_DEF0, 2'b01, 1'b1, "R7 self-sync after seed");
    put(64'h0, 2'b10, 1'b1, "R7 self-sync chained");
    // back to frame mode
    put(64'h7777, 2'b01, 1'b0, "R11 sync on return");
    put(64'h7777, 2'b10, 1'b0, "R4 state word after self mode");
    put(64'h0, 2'b01, 1'b0, "R5 payload after self mode");
    idle(4);
    check(q_data.size() == 0, "R2 all results produced", 64'(q_data.size()), 64'd0);
    done = 1'b1;
    summary();
  end
endmodule